// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the one-shot countdown timer of a memory-mapped local interrupt controller. A prescaler turns the core clock into count ticks, using a divisor from 1 to 128. The divisor comes from a small divide register. Software writes a 32-bit start value to the initial count register, and the timer then counts that many ticks down. A one-cycle `timeout` pulse marks expiry. At any time software can read the current count register to learn how many ticks are still left.

The prescaler runs freely from reset release. Each period starts with a "tick start" cycle, and the first cycle after reset is one. If a start value is written in a cycle that is not a tick start, the countdown first waits for the next tick start and only then begins. This rounds a partial tick up to a whole one. All three registers sit on a simple bus with address, write enable, write data, read enable and read data. Read data is registered and appears in the cycle after the read enable.

Top module: `lic_timer`

## Requirements
- R1: The divide code is {cfg[3], cfg[1], cfg[0]} with cfg[3] as the most significant bit. The divisor is 2 to the power ((code + 1) mod 8). So 3'b111 gives 1, 3'b000 gives 2, 3'b010 gives 8, 3'b100 gives 32 and 3'b110 gives 128.
- R2: A write to the divide register at offset 0x3E0 keeps only the bits under mask 0xB. A read returns the kept bits, with all other bits zero. After reset the divide register reads 0, which selects divide by 2.
- R3: Writing a nonzero N to the initial count register (offset 0x380) in a tick start cycle raises `timeout` N*div clock edges after the edge that accepts the write.
- R4: Writing a nonzero N in a cycle at phase p (p ≠ 0) within the current tick raises `timeout` (div − p) + N*div edges after the accepting edge.
- R5: A read of the current count register (offset 0x390) returns the number of tick starts still to pass before expiry. This equals the cycles left until the pulse divided by the divisor and rounded up, so right after an N write at phase p ≠ 0 it reads N+1. The value saturates at 0xFFFFFFFF and is 0 when no countdown runs. A read of the initial count register returns the last value written to it. Read data appears in the cycle after `rd_en` and is 0 when `rd_en` was low or the address is not one of the three registers.
- R6: A write to the current count register, or to any address other than the three registers, changes nothing: both the expiry time and the values read back stay the same.
- R7: Writing 0 to the initial count stops a running countdown with no `timeout` pulse, and the current count then reads 0.
- R8: `timeout` is high for exactly one cycle per expiry. After it, the current count reads 0.
- R9: A new divide value takes effect at the next tick start. The tick in progress finishes at the old length.
- R10: Writing a new initial count while a countdown runs restarts it from the new value, and the old expiry never occurs.
- R11: After reset, `timeout` is low and all three registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W (12) | Register byte offset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_data | output | DATA_W (32) | Read data, valid the cycle after `rd_en` |
| timeout | output | 1 | One-cycle expiry pulse |

## Verification
Start values are written at tick starts and at nonzero phases under several divisors. Comparing the measured delays tells a correct round-up of a partial tick apart from an immediate start or an extra tick. The divide code is changed in the middle of a tick. This shows whether the new rate waits for the next tick start or is applied at once. Writes of zero, restarting writes, writes to the read-only count and writes to unused offsets are followed by a measurement of expiry timing and by read-backs, to show that each is either honoured or ignored. A behavioural reference model compares the pulse output and the read data on every cycle.

// File: rtl/lct_pkg.sv
package lct_pkg;
    localparam int CODE_W    = 3;
    localparam int CFG_W     = 4;
    localparam int SHIFT_MAX = (1 << CODE_W) - 1;
    localparam int PH_W      = SHIFT_MAX;
    localparam logic [CFG_W-1:0] CFG_KEEP = 4'hB;

    typedef logic [CODE_W-1:0] shift_t;
    typedef logic [PH_W-1:0]   phase_t;

    typedef struct packed {
        phase_t ph;
        shift_t sh;
    } presc_t;
endpackage

// File: rtl/lct_div_decode.sv
module lct_div_decode
    import lct_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    output shift_t           shift
);
    shift_t code;

    always_comb begin
        code  = {cfg[3], cfg[1:0]};
        shift = code + shift_t'(1);
    end
endmodule

// File: rtl/lct_prescaler.sv
module lct_prescaler
    import lct_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  shift_t shift_new,
    output logic   tick_start,
    output shift_t shift_cur
);
    presc_t st_d, st_q;
    phase_t lim;

    always_comb begin
        lim  = (phase_t'(1) << st_q.sh) - phase_t'(1);
        st_d = st_q;
        if (st_q.ph == lim) begin
            st_d.ph = '0;
            st_d.sh = shift_new;
        end else begin
            st_d.ph = st_q.ph + phase_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph <= '0;
            st_q.sh <= shift_t'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_start = (st_q.ph == '0);
    assign shift_cur  = st_q.sh;

    // R1: the phase never runs past the period chosen by the active divisor
    p_phase_in_period_r1: assert property (@(posedge clk) disable iff (rst)
        st_q.ph <= lim);

    // R9: the active divisor changes only as a new tick starts
    p_rate_change_at_tick_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q.sh != $past(st_q.sh)) |-> (st_q.ph == '0));
endmodule

// File: rtl/lct_countdown.sv
module lct_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick_start,
    output logic [CNT_W-1:0] remaining,
    output logic             expired
);
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [EXT_W-1:0] cnt;
        logic             run;
        logic             pulse;
    } cd_t;

    cd_t              st_d, st_q;
    logic [EXT_W-1:0] extra;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        extra      = tick_start ? '0 : EXT_W'(1);
        if (load) begin
            if (load_val == '0) begin
                st_d.cnt = '0;
                st_d.run = 1'b0;
            end else begin
                st_d.cnt = {1'b0, load_val} + extra;
                st_d.run = 1'b1;
            end
        end else if (st_q.run && tick_start) begin
            if (st_q.cnt == EXT_W'(1)) begin
                st_d.cnt   = '0;
                st_d.run   = 1'b0;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - EXT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign remaining = st_q.cnt[CNT_W] ? '1 : st_q.cnt[CNT_W-1:0];
    assign expired   = st_q.pulse;

    // R8: the expiry pulse lasts a single cycle
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |=> !st_q.pulse);

    // R8: the count is empty and idle while the pulse is shown
    p_idle_at_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |-> (!st_q.run && st_q.cnt == '0));

    // R7: a zero start value never leads to a pulse
    p_zero_load_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (load && load_val == '0) |=> !st_q.pulse);

    // R3: without a load, the count moves only on a tick start
    p_step_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        ((st_q.cnt != $past(st_q.cnt)) && !$past(load)) |-> $past(tick_start));
endmodule

// File: rtl/lic_timer.sv
module lic_timer
    import lct_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter logic [ADDR_W-1:0] A_INIT = 12'h380,
    parameter logic [ADDR_W-1:0] A_CUR  = 12'h390,
    parameter logic [ADDR_W-1:0] A_CFG  = 12'h3E0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout
);
    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [CNT_W-1:0]  init;
        logic [DATA_W-1:0] rd;
    } regs_t;

    regs_t            st_d, st_q;
    logic             load;
    logic [CNT_W-1:0] cur_count;
    logic             tick_start;
    shift_t           shift_new;
    shift_t           shift_cur;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (wr_en) begin
            if (addr == A_CFG) begin
                st_d.cfg = wr_data[CFG_W-1:0] & CFG_KEEP;
            end else if (addr == A_INIT) begin
                st_d.init = wr_data[CNT_W-1:0];
                load      = 1'b1;
            end
        end
        st_d.rd = '0;
        if (rd_en) begin
            if (addr == A_CFG) begin
                st_d.rd = DATA_W'(st_q.cfg);
            end else if (addr == A_INIT) begin
                st_d.rd = DATA_W'(st_q.init);
            end else if (addr == A_CUR) begin
                st_d.rd = DATA_W'(cur_count);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    lct_div_decode u_decode (
        .cfg   (st_q.cfg),
        .shift (shift_new)
    );

    lct_prescaler u_presc (
        .clk        (clk),
        .rst        (rst),
        .shift_new  (shift_new),
        .tick_start (tick_start),
        .shift_cur  (shift_cur)
    );

    lct_countdown #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (wr_data[CNT_W-1:0]),
        .tick_start (tick_start),
        .remaining  (cur_count),
        .expired    (timeout)
    );

    assign rd_data = st_q.rd;

    // R2: the divide register reads back with only the masked bits possible
    p_cfg_readback_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && addr == A_CFG) |-> ((rd_data & ~DATA_W'(CFG_KEEP)) == '0));

    // R6: writing the read-only count leaves it alone between tick starts
    p_cur_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CUR && !tick_start) |=> $stable(cur_count));

    // R5: reads of unmapped offsets return zero
    p_unmapped_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && addr != A_CFG && addr != A_INIT && addr != A_CUR) |-> (rd_data == '0));

    // R9: the prescaler only changes the active divisor at a tick start
    p_shift_held_mid_tick_r9: assert property (@(posedge clk) disable iff (rst)
        !tick_start |-> (shift_cur == $past(shift_cur)));
endmodule

// File: tb/test_lic_timer.sv
`timescale 1ns/1ps
module test_lic_timer;
    localparam logic [11:0] A_INIT = 12'h380;
    localparam logic [11:0] A_CUR  = 12'h390;
    localparam logic [11:0] A_CFG  = 12'h3E0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        timeout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    lic_timer i_lic_timer (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .timeout(timeout)
    );

    // behavioural reference model
    int     m_ph, m_sh, m_cfg;
    longint m_init, m_cnt, m_rd;
    bit     m_to;

    function automatic int div_shift(int c);
        return ((((c >> 1) & 4) | (c & 3)) + 1) % 8;
    endfunction

    always @(posedge clk) begin
        longint nrd;
        if (rst) begin
            m_ph = 0; m_sh = 1; m_cfg = 0; m_init = 0; m_cnt = 0; m_rd = 0; m_to = 0;
        end else begin
            nrd = 0;
            if (rd_en) begin
                if (addr == A_CFG) nrd = m_cfg;
                else if (addr == A_INIT) nrd = m_init;
                else if (addr == A_CUR) nrd = (m_cnt > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : m_cnt;
            end
            m_to = 0;
            if (wr_en && addr == A_INIT) begin
                m_init = wr_data;
                m_cnt  = (wr_data == 0) ? 0 : longint'(wr_data) + ((m_ph != 0) ? 1 : 0);
            end else if (m_cnt != 0 && m_ph == 0) begin
                m_cnt--;
                if (m_cnt == 0) m_to = 1;
            end
            if (m_ph == (1 << m_sh) - 1) begin
                m_ph = 0;
                m_sh = div_shift(m_cfg);
            end else begin
                m_ph++;
            end
            if (wr_en && addr == A_CFG) m_cfg = int'(wr_data & 32'hB);
            m_rd = nrd;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_cmp += 2;
            if (timeout !== m_to) begin
                n_bad++;
                $display("FAIL R3/R4/R8 timeout per-cycle: actual %0b expected %0b", timeout, m_to);
            end
            if (rd_data !== 32'(m_rd)) begin
                n_bad++;
                $display("FAIL R5 read data per-cycle: actual %0h expected %0h", rd_data, m_rd);
            end
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    // counts negedges from the write edge until the pulse; n starts at the given index
    task automatic wait_pulse(int start, int limit, output int n);
        n = start;
        while (!timeout && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_tick(int sh);
        while (!(m_sh == sh && m_ph == 0)) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int n, p, hits;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 timeout after reset", timeout, 0);
        rd(A_CFG, v);  chk("R11 cfg after reset", v, 0);
        rd(A_INIT, v); chk("R11 init after reset", v, 0);
        rd(A_CUR, v);  chk("R11 cur after reset", v, 0);

        // R1 default divide by 2, aligned start
        wait_tick(1);
        wr(A_INIT, 2); wait_pulse(1, 100, n);
        chk("R1 div2 N=2 delay", n, 5);

        // R2 mask
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, v); chk("R2 cfg readback masked", v, 32'hB);

        // R3 divide by 1
        wait_tick(0);
        wr(A_INIT, 5); wait_pulse(1, 100, n);
        chk("R3 div1 N=5 delay", n, 6);
        // R8 one cycle, count zero after
        @(negedge clk); chk("R8 pulse one cycle", timeout, 0);
        rd(A_CUR, v); chk("R8 cur zero after expiry", v, 0);

        // R3 and R4 divide by 4 (code 001)
        wr(A_CFG, 32'h1);
        wait_tick(2);
        wr(A_INIT, 3); wait_pulse(1, 200, n);
        chk("R3 div4 aligned delay", n, 13);
        while (m_ph != 2) @(negedge clk);
        p = m_ph;
        wr(A_INIT, 3);
        rd(A_CUR, v); chk("R5 cur after mid-tick write", v, 4);
        wait_pulse(2, 200, n);
        chk("R4 div4 mid-tick delay", n, (4 - p) + 12 + 1);

        // R5 reads during a run (compared by the model each cycle)
        wait_tick(2);
        wr(A_INIT, 10);
        rd(A_INIT, v); chk("R5 init readback", v, 10);
        for (int i = 0; i < 12; i++) rd(A_CUR, v);
        wait_pulse(0, 200, n);

        // R9 divisor change mid-tick: old tick finishes at length 4
        wait_tick(2);
        wr(A_INIT, 2);
        wr(A_CFG, 32'hB);
        wait_pulse(2, 200, n);
        chk("R9 rate change at next tick", n, 6);

        // R6 write to current count and to an unused offset
        wait_tick(0);
        wr(A_INIT, 40);
        wr(A_CUR, 32'h7);
        wr(12'h100, 32'hFFFF);
        wait_pulse(3, 200, n);
        chk("R6 expiry unchanged by ignored writes", n, 41);
        rd(A_CFG, v); chk("R6 cfg unchanged", v, 32'hB);
        rd(12'h100, v); chk("R6 unused offset reads zero", v, 0);

        // R7 zero write stops silently
        wr(A_INIT, 5);
        wr(A_INIT, 0);
        hits = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (timeout) hits++;
        end
        chk("R7 no pulse after zero write", hits, 0);
        rd(A_CUR, v); chk("R7 cur zero after stop", v, 0);

        // R10 restart while running
        wr(A_INIT, 100);
        repeat (10) @(negedge clk);
        wr(A_INIT, 3); wait_pulse(1, 300, n);
        chk("R10 restart delay", n, 4);
        hits = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (timeout) hits++;
        end
        chk("R10 old expiry never fires", hits, 0);

        // R1 divide by 128 (code 110) and by 32 (code 100)
        wr(A_CFG, 32'hA);
        wait_tick(7);
        wr(A_INIT, 1); wait_pulse(1, 400, n);
        chk("R1 div128 N=1 delay", n, 129);
        wr(A_CFG, 32'h8);
        wait_tick(5);
        wr(A_INIT, 2); wait_pulse(1, 400, n);
        chk("R1 div32 N=2 delay", n, 65);

        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule